// File: doc/BRIEF.md
# Operator Envelope Generator with Repeating Mode

This block produces the attenuation curve of a single FM operator. A key-on strobe starts an attack that falls from full attenuation towards zero. A first decay follows and rises towards a programmed sustain level. A second decay then keeps rising slowly while the key is held. A key-off strobe starts a release that ends in silence. Every change of level happens on a global envelope tick. The rate that applies in each phase decides on which ticks a step is taken and how large that step is, from a small computed lookup.

An optional repeating mode turns the second-decay phase into a loop. Once the attenuation reaches the halfway code, the envelope either freezes (hold) or restarts as if keyed again. A restart pulses a phase-reset strobe for the oscillator and can flip an output inversion flag (alternate). In this mode, steps in both decay phases and in release are six times larger. The output is the attenuation, inverted when the mode asks for it, plus the total level, saturated at full scale.

All pins are plain control and status pins. The block has no data stream and no back-pressure: strobes take effect in the cycle they are high.

Top module: `eg_ssg_env`

## Requirements
- R1: After reset `env_att` is 1023, `phase_rst` is 0, the envelope is idle and the tick counter is 0. The internal phase order is idle < release < second decay < first decay < attack.
- R2: Effective rate is 0 when the 5-bit rate is 0, and otherwise min(63, 2*rate + `ksr_ofs`). A `key_on` while idle or releasing raises `phase_rst` for exactly one cycle. If the attack effective rate is below 62, the envelope enters attack with attenuation 1023. Otherwise it enters first decay with attenuation 0.
- R3: A `key_on` while the key is held, and a `key_off` while it is not, have no effect: no `phase_rst` and no change in the following output.
- R4: The internal counter increments on each `eg_tick`. A step happens only when the incremented counter has its low S bits zero, where S = 11 - eff/4 for eff < 48 and S = 0 otherwise. With idx = counter bits [S+2:S], row = eff mod 4 and p = idx[0], or idx=4 for row 1, or idx in {2,6} for row 2, or idx≠0 for row 3, the increment is: 0 for eff=0; p for eff<48; (1+p) << (eff/4-12) for eff<60; 8 otherwise.
- R5: Each attack step subtracts ceil((att+1)*inc/16). When that reaches or passes zero, attenuation becomes 0 and the first decay starts.
- R6: In first decay, each step adds the increment (times 6 when `ssg_ctl[3]` is set). On every tick, stepped or not, an attenuation at or above the sustain level (`sus_lvl`*32, or 1023 for `sus_lvl`=15) is clamped to it and the second decay starts.
- R7: With `ssg_ctl[3]` clear, the second decay adds its steps with saturation at 1023 and stays in that phase.
- R8: `key_off` while keyed moves any active phase to release. Release adds its steps (times 6 with `ssg_ctl[3]`). At 1023 or more it becomes 1023 and the envelope goes idle.
- R9: With `ssg_ctl[3]` set, a tick in second decay with attenuation ≥ 512 does one of two things. With `ssg_ctl[0]` (hold) set, it freezes. Otherwise it restarts: `phase_rst` pulses, then the envelope enters attack with its attenuation kept if the attack effective rate is below 62. If not, the attenuation becomes 0 and the next phase is second decay when `sus_lvl` is 0, or first decay otherwise.
- R10: Key-on loads the inversion flag from `ssg_ctl[2]`. A restart with `ssg_ctl[1]` set toggles the flag after that tick's output has been captured.
- R11: `env_att` changes only on tick cycles. It equals min(1023, v + 8*`tot_lvl`), where v is the attenuation XOR 1023 when `ssg_ctl[3]` and the inversion flag are set and the envelope is in attack or either decay, and the plain attenuation otherwise. v is taken from the values after that tick's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_on | input | 1 | Key-on strobe |
| key_off | input | 1 | Key-off strobe |
| eg_tick | input | 1 | Global envelope tick |
| ar_rate | input | 5 | Attack rate |
| d1_rate | input | 5 | First-decay rate |
| d2_rate | input | 5 | Second-decay rate |
| rel_rate | input | 5 | Release rate |
| ksr_ofs | input | 5 | Key-scale rate offset |
| sus_lvl | input | 4 | Sustain level |
| tot_lvl | input | 7 | Total level |
| ssg_ctl | input | 4 | Repeat mode: [3] enable, [2] initial invert, [1] alternate, [0] hold |
| env_att | output | 10 | Attenuation output |
| phase_rst | output | 1 | Phase-reset strobe |

## Verification
Some rules are checked on every cycle. These are: the output stays still on cycles without a tick; an accepted key-on is followed by a single-cycle phase reset; a repeated key-on leaves the phase unchanged; key-off leads to release; attack never raises the attenuation; the idle phase always holds full attenuation. The exact curves depend on rate-table values, counter alignment, the six-fold steps, restart targets and the timing of the inversion toggle. Only the bench's cycle-exact reference model can show these, run over normal, maximum-attack, saturated-level, alternate, invert-start and hold scenarios.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef enum logic [2:0] {
    EG_OFF = 3'd0,
    EG_REL = 3'd1,
    EG_SUS = 3'd2,
    EG_DEC = 3'd3,
    EG_ATT = 3'd4
  } eg_state_e;

  localparam int EFF_W     = 6;
  localparam int EFF_MAX   = 63;
  localparam int ATT_SKIP  = 62;
  localparam int FAST_BASE = 48;
  localparam int TOP_BASE  = 60;
endpackage

// File: rtl/eg_rate_calc.sv
module eg_rate_calc import eg_pkg::*; #(
  parameter int RATE_W = 5,
  parameter int KSR_W  = 5
) (
  input  logic [RATE_W-1:0] rate,
  input  logic [KSR_W-1:0]  ksr,
  output logic [EFF_W-1:0]  eff,
  output logic [3:0]        shift,
  output logic [1:0]        row
);
  localparam int SUM_W = RATE_W + 2;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, rate, 1'b0} + SUM_W'(ksr);
    if (rate == '0)
      eff = '0;
    else if (sum > SUM_W'(EFF_MAX))
      eff = EFF_W'(EFF_MAX);
    else
      eff = EFF_W'(sum);
    shift = (eff < EFF_W'(FAST_BASE)) ? (4'd11 - eff[5:2]) : 4'd0;
    row   = eff[1:0];
  end
endmodule

// File: rtl/eg_increment.sv
module eg_increment import eg_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [EFF_W-1:0] eff,
  input  logic [3:0]       shift,
  input  logic [1:0]       row,
  output logic             step_en,
  output logic [3:0]       inc
);
  logic [CNT_W-1:0] mask;
  logic [2:0]       idx;
  logic             p;

  always_comb begin
    mask    = (CNT_W'(1) << shift) - CNT_W'(1);
    step_en = tick && ((cnt & mask) == '0);
    idx     = 3'(cnt >> shift);
    p = idx[0]
      | ((row == 2'd1) && (idx == 3'd4))
      | ((row == 2'd2) && ((idx == 3'd2) || (idx == 3'd6)))
      | ((row == 2'd3) && (idx != 3'd0));
    if (eff == '0)
      inc = 4'd0;
    else if (eff < EFF_W'(FAST_BASE))
      inc = {3'b000, p};
    else if (eff < EFF_W'(TOP_BASE))
      inc = (4'd1 + {3'b000, p}) << (eff[5:2] - 4'd12);
    else
      inc = 4'd8;
  end
endmodule

// File: rtl/eg_ssg_env.sv
module eg_ssg_env import eg_pkg::*; #(
  parameter int ATT_W  = 10,
  parameter int RATE_W = 5,
  parameter int KSR_W  = 5,
  parameter int SL_W   = 4,
  parameter int TL_W   = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_on,
  input  logic              key_off,
  input  logic              eg_tick,
  input  logic [RATE_W-1:0] ar_rate,
  input  logic [RATE_W-1:0] d1_rate,
  input  logic [RATE_W-1:0] d2_rate,
  input  logic [RATE_W-1:0] rel_rate,
  input  logic [KSR_W-1:0]  ksr_ofs,
  input  logic [SL_W-1:0]   sus_lvl,
  input  logic [TL_W-1:0]   tot_lvl,
  input  logic [3:0]        ssg_ctl,
  output logic [ATT_W-1:0]  env_att,
  output logic              phase_rst
);
  localparam logic [ATT_W-1:0] ATT_MAX  = '1;
  localparam logic [ATT_W-1:0] SSG_HALF = ATT_W'(1) << (ATT_W - 1);
  localparam int SL_SH = ATT_W - SL_W - 1;
  localparam int TL_SH = ATT_W - TL_W;
  localparam int NRATE = 4;

  eg_state_e        state_q, st_n;
  logic [ATT_W-1:0] att_q, att_n;
  logic             inv_q, inv_n, keyed_q, keyed_n;
  logic             rst_pulse, swap;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  // per-phase rate decode, one per rate input
  logic [RATE_W-1:0] rate_v [NRATE];
  logic [EFF_W-1:0]  eff_v  [NRATE];
  logic [3:0]        sh_v   [NRATE];
  logic [1:0]        row_v  [NRATE];

  assign rate_v[0] = ar_rate;
  assign rate_v[1] = d1_rate;
  assign rate_v[2] = d2_rate;
  assign rate_v[3] = rel_rate;

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    eg_rate_calc #(.RATE_W(RATE_W), .KSR_W(KSR_W)) u_rc (
      .rate (rate_v[g]),
      .ksr  (ksr_ofs),
      .eff  (eff_v[g]),
      .shift(sh_v[g]),
      .row  (row_v[g])
    );
  end

  logic [1:0] rsel;
  always_comb begin
    unique case (state_q)
      EG_ATT:  rsel = 2'd0;
      EG_DEC:  rsel = 2'd1;
      EG_SUS:  rsel = 2'd2;
      default: rsel = 2'd3;
    endcase
  end

  assign cnt_nx = cnt_q + CNT_W'(1);

  logic       step_en;
  logic [3:0] inc;
  eg_increment #(.CNT_W(CNT_W)) u_inc (
    .tick   (eg_tick),
    .cnt    (cnt_nx),
    .eff    (eff_v[rsel]),
    .shift  (sh_v[rsel]),
    .row    (row_v[rsel]),
    .step_en(step_en),
    .inc    (inc)
  );

  // step arithmetic
  logic [ATT_W-1:0] sl_att, add_sat, dec_cand;
  logic [5:0]       amt;
  logic [ATT_W:0]   add_full, atk_dec;
  logic [ATT_W+4:0] atk_prod;
  logic             ssg_on, skip_atk;

  always_comb begin
    ssg_on   = ssg_ctl[3];
    skip_atk = (eff_v[0] >= EFF_W'(ATT_SKIP));
    sl_att   = (&sus_lvl) ? ATT_MAX : (ATT_W'(sus_lvl) << SL_SH);
    amt      = (ssg_on && state_q != EG_ATT) ? (6'(inc) * 6'd6) : 6'(inc);
    add_full = {1'b0, att_q} + (ATT_W+1)'(amt);
    add_sat  = add_full[ATT_W] ? ATT_MAX : add_full[ATT_W-1:0];
    atk_prod = ((ATT_W+5)'(att_q) + (ATT_W+5)'(1)) * (ATT_W+5)'(inc) + (ATT_W+5)'(15);
    atk_dec  = atk_prod[ATT_W+4:4];
    dec_cand = step_en ? add_sat : att_q;
  end

  // phase sequencing
  always_comb begin
    st_n      = state_q;
    att_n     = att_q;
    inv_n     = inv_q;
    keyed_n   = keyed_q;
    rst_pulse = 1'b0;
    swap      = 1'b0;
    if (key_on && !keyed_q) begin
      keyed_n   = 1'b1;
      rst_pulse = 1'b1;
      inv_n     = ssg_ctl[2];
      if (!skip_atk) begin
        st_n  = EG_ATT;
        att_n = ATT_MAX;
      end else begin
        st_n  = EG_DEC;
        att_n = '0;
      end
    end else if (key_off && keyed_q) begin
      keyed_n = 1'b0;
      if (state_q != EG_OFF) st_n = EG_REL;
    end else if (eg_tick) begin
      unique case (state_q)
        EG_ATT: begin
          if (step_en && inc != 4'd0) begin
            if (atk_dec >= {1'b0, att_q}) begin
              att_n = '0;
              st_n  = EG_DEC;
            end else begin
              att_n = att_q - atk_dec[ATT_W-1:0];
            end
          end
        end
        EG_DEC: begin
          if (dec_cand >= sl_att) begin
            att_n = sl_att;
            st_n  = EG_SUS;
          end else begin
            att_n = dec_cand;
          end
        end
        EG_SUS: begin
          if (ssg_on && att_q >= SSG_HALF) begin
            if (!ssg_ctl[0]) begin
              rst_pulse = 1'b1;
              swap      = ssg_ctl[1];
              if (!skip_atk) begin
                st_n = EG_ATT;
              end else begin
                att_n = '0;
                st_n  = (sus_lvl == '0) ? EG_SUS : EG_DEC;
              end
            end
          end else if (step_en) begin
            att_n = add_sat;
          end
        end
        EG_REL: begin
          if (step_en) begin
            if (add_full >= (ATT_W+1)'(ATT_MAX)) begin
              att_n = ATT_MAX;
              st_n  = EG_OFF;
            end else begin
              att_n = add_full[ATT_W-1:0];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // output level: new attenuation, inversion flag before any toggle
  logic [ATT_W-1:0] shown, out_sat;
  logic [ATT_W:0]   out_sum;
  always_comb begin
    shown   = (ssg_on && inv_q && st_n > EG_REL) ? (att_n ^ ATT_MAX) : att_n;
    out_sum = {1'b0, shown} + ((ATT_W+1)'(tot_lvl) << TL_SH);
    out_sat = out_sum[ATT_W] ? ATT_MAX : out_sum[ATT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= EG_OFF;
      att_q     <= ATT_MAX;
      inv_q     <= 1'b0;
      keyed_q   <= 1'b0;
      cnt_q     <= '0;
      env_att   <= ATT_MAX;
      phase_rst <= 1'b0;
    end else begin
      state_q   <= st_n;
      att_q     <= att_n;
      inv_q     <= inv_n ^ swap;
      keyed_q   <= keyed_n;
      phase_rst <= rst_pulse;
      if (eg_tick) begin
        cnt_q   <= cnt_nx;
        env_att <= out_sat;
      end
    end
  end
endmodule

// File: rtl/eg_ssg_env_chk.sv
module eg_ssg_env_chk import eg_pkg::*; #(
  parameter int ATT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_on,
  input logic             key_off,
  input logic             eg_tick,
  input logic [ATT_W-1:0] env_att,
  input logic             phase_rst,
  input logic [2:0]       state_q,
  input logic [ATT_W-1:0] att_q,
  input logic             keyed_q
);
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eg_tick |=> $stable(env_att));

  // R2
  keyon_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on && !keyed_q) |=> phase_rst);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> !phase_rst);

  // R3
  repeat_keyon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on && keyed_q && !key_off && !eg_tick) |=> (!phase_rst && $stable(state_q)));

  // R8
  keyoff_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_off && keyed_q && state_q != 3'(EG_OFF)) |=> (state_q == 3'(EG_REL)));

  // R5
  attack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(EG_ATT) && !key_off) |=> (att_q <= $past(att_q)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(EG_OFF)) |-> (att_q == ATT_MAX));
endmodule

bind eg_ssg_env eg_ssg_env_chk #(.ATT_W(ATT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .key_on   (key_on),
  .key_off  (key_off),
  .eg_tick  (eg_tick),
  .env_att  (env_att),
  .phase_rst(phase_rst),
  .state_q  (state_q),
  .att_q    (att_q),
  .keyed_q  (keyed_q)
);

// File: tb/sim_eg_ssg_env.sv
`timescale 1ns/1ps
module sim_eg_ssg_env;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_on = 1'b0, key_off = 1'b0, eg_tick = 1'b0;
  logic [4:0] ar_rate = 5'd20, d1_rate = 5'd24, d2_rate = 5'd12, rel_rate = 5'd28;
  logic [4:0] ksr_ofs = 5'd0;
  logic [3:0] sus_lvl = 4'd4;
  logic [6:0] tot_lvl = 7'd0;
  logic [3:0] ssg_ctl = 4'd0;
  logic [9:0] env_att;
  logic       phase_rst;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eg_ssg_env u0 (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off), .eg_tick(eg_tick),
    .ar_rate(ar_rate), .d1_rate(d1_rate), .d2_rate(d2_rate), .rel_rate(rel_rate),
    .ksr_ofs(ksr_ofs), .sus_lvl(sus_lvl), .tot_lvl(tot_lvl), .ssg_ctl(ssg_ctl),
    .env_att(env_att), .phase_rst(phase_rst)
  );

  typedef struct { int att; bit rst; string tag; } exp_t;
  exp_t q[$];

  // reference model state: 0 idle, 1 release, 2 second decay, 3 first decay, 4 attack
  int m_st = 0, m_att = 1023, m_inv = 0, m_keyed = 0, m_cnt = 0, m_out = 1023;

  function automatic int eff_f(int r);
    int s = 2 * r + int'(ksr_ofs);
    if (r == 0) return 0;
    return (s > 63) ? 63 : s;
  endfunction

  function automatic int shift_f(int e);
    return (e < 48) ? 11 - e / 4 : 0;
  endfunction

  function automatic int inc_f(int e, int c);
    int idx = (c >> shift_f(e)) & 7;
    int row = e % 4;
    int p = ((idx % 2) == 1) || (row == 1 && idx == 4) ||
            (row == 2 && (idx == 2 || idx == 6)) || (row == 3 && idx != 0);
    if (e == 0) return 0;
    if (e < 48) return p;
    if (e < 60) return (1 + p) << (e / 4 - 12);
    return 8;
  endfunction

  task automatic model(bit kon, bit koff, bit tk, output exp_t e);
    int rst = 0, swp = 0, e_ar, slv, r, ef, sh, stp, inc, amt, add, addsat, d, a, show;
    string tag;
    e_ar = eff_f(int'(ar_rate));
    slv = (sus_lvl == 4'd15) ? 1023 : int'(sus_lvl) * 32;
    if (tk) m_cnt = (m_cnt + 1) & 16'hFFFF;
    if (kon && m_keyed == 0) begin
      m_keyed = 1; rst = 1; m_inv = int'(ssg_ctl[2]); tag = "R2";
      if (e_ar < 62) begin m_st = 4; m_att = 1023; end
      else begin m_st = 3; m_att = 0; end
    end else if (koff && m_keyed == 1) begin
      m_keyed = 0; tag = "R8";
      if (m_st != 0) m_st = 1;
    end else if (kon || koff) begin
      tag = "R3";
    end else if (tk) begin
      case (m_st)
        4: tag = "R4 R5";
        3: tag = "R4 R6";
        2: tag = ssg_ctl[3] ? "R9 R10" : "R4 R7";
        default: tag = "R8";
      endcase
      if (tot_lvl != 0) tag = {tag, " R11"};
      r = (m_st == 4) ? int'(ar_rate) : (m_st == 3) ? int'(d1_rate) :
          (m_st == 2) ? int'(d2_rate) : int'(rel_rate);
      ef = eff_f(r); sh = shift_f(ef);
      stp = ((m_cnt % (1 << sh)) == 0);
      inc = inc_f(ef, m_cnt);
      amt = (ssg_ctl[3] && m_st != 4) ? 6 * inc : inc;
      add = m_att + amt;
      addsat = (add > 1023) ? 1023 : add;
      case (m_st)
        4: if (stp) begin
             d = ((m_att + 1) * inc + 15) / 16;
             if (d >= m_att) begin m_att = 0; m_st = 3; end
             else m_att = m_att - d;
           end
        3: begin
             a = stp ? addsat : m_att;
             if (a >= slv) begin m_att = slv; m_st = 2; end
             else m_att = a;
           end
        2: if (ssg_ctl[3] && m_att >= 512) begin
             if (!ssg_ctl[0]) begin
               rst = 1; swp = int'(ssg_ctl[1]);
               if (e_ar < 62) m_st = 4;
               else begin m_att = 0; m_st = (sus_lvl == 0) ? 2 : 3; end
             end
           end else if (stp) m_att = addsat;
        1: if (stp) begin
             if (add >= 1023) begin m_att = 1023; m_st = 0; end
             else m_att = add;
           end
        default: ;
      endcase
    end else begin
      tag = "R11";
    end
    if (tk) begin
      show = (ssg_ctl[3] && m_inv == 1 && m_st > 1) ? (m_att ^ 1023) : m_att;
      m_out = show + int'(tot_lvl) * 8;
      if (m_out > 1023) m_out = 1023;
    end
    m_inv = m_inv ^ swp;
    e.att = m_out; e.rst = rst[0]; e.tag = tag;
  endtask

  task automatic cyc(bit kon, bit koff, bit tk);
    exp_t e;
    key_on = kon; key_off = koff; eg_tick = tk;
    model(kon, koff, tk, e);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (int'(env_att) != e.att) begin
        errors++;
        $display("FAIL %s env_att got %0d expected %0d", e.tag, env_att, e.att);
      end
      checks++;
      if (phase_rst !== e.rst) begin
        errors++;
        $display("FAIL %s phase_rst got %0b expected %0b", e.tag, phase_rst, e.rst);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (env_att !== 10'd1023 || phase_rst !== 1'b0) begin
      errors++;
      $display("FAIL R1 env_att/phase_rst got %0d/%0b expected 1023/0", env_att, phase_rst);
    end

    // normal envelope: attack, first decay, second decay, release
    cyc(1, 0, 0);
    ticks(2000);
    repeat (5) cyc(0, 0, 0);
    cyc(1, 0, 0);
    ticks(3);
    cyc(0, 1, 0);
    ticks(400);
    cyc(0, 1, 0);
    ticks(3);

    // maximum attack rate, zero sustain, decay rate zero
    ar_rate = 5'd31; sus_lvl = 4'd0; d1_rate = 5'd0; d2_rate = 5'd0;
    cyc(1, 0, 0);
    ticks(10);
    cyc(0, 1, 0);
    ticks(400);

    // total level saturation
    tot_lvl = 7'd127; sus_lvl = 4'd15; d1_rate = 5'd28;
    cyc(1, 0, 0);
    ticks(300);
    cyc(0, 1, 0);
    ticks(400);
    tot_lvl = 7'd0;

    // repeating mode with alternate
    ssg_ctl = 4'b1010; sus_lvl = 4'd4; d1_rate = 5'd28; d2_rate = 5'd28; rel_rate = 5'd28;
    cyc(1, 0, 0);
    ticks(600);
    cyc(0, 1, 0);
    ticks(200);

    // repeating mode with inverted start and a real attack
    ssg_ctl = 4'b1100; ar_rate = 5'd24;
    cyc(1, 0, 0);
    ticks(800);
    cyc(0, 1, 0);
    ticks(200);

    // repeating mode with hold
    ssg_ctl = 4'b1001; ar_rate = 5'd31;
    cyc(1, 0, 0);
    ticks(400);
    repeat (4) cyc(0, 0, 0);
    cyc(0, 1, 0);
    ticks(200);

    key_on = 0; key_off = 0; eg_tick = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule